// File: doc/BRIEF.md
# Timed Event Stream Player

This block replays a list of timed output events that was recorded into memory earlier. Software places the stream start address on `base_addr` and a 64-bit time shift on `time_ofs`, then pulses `start`. The player reads the stream one byte at a time through a single-outstanding read port. It rebuilds each variable-length record from its little-endian byte fields and presents one output command per record on a valid/ready port. The command carries the channel, the address byte, the shifted timestamp and up to sixteen data words.

Each record has a 13-byte header followed by its data words. The header holds the total length byte, three channel bytes, eight timestamp bytes and one address byte, in that order. A length byte of zero ends the stream, and the player then returns to idle. While a command is accepted, the sink reports whether the event was already late or aimed at a channel that does not exist. The player keeps sticky error flags, clears them one bit at a time on write-one-to-clear, and records the time and channel of the first failing event. Playback continues after an error.

Top module: `evdma_player`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low and the low 7 bits of `base_addr` are zero (128-byte alignment). Any other pulse is ignored and leaves `busy` low or leaves the current playback untouched.
- R2: `busy` rises in the cycle after an accepted start. It stays high until the zero length byte has been read, and it is low again at that point. While `busy` is low, `mem_rd` and `cmd_valid` stay low.
- R3: Record byte layout, counted from the record's first byte: byte 0 holds the length L. Bytes 1..3 hold `cmd_chan` least-significant byte first. Bytes 4..11 hold the 64-bit timestamp least-significant byte first. Byte 12 holds `cmd_addr`.
- R4: Data word i occupies bytes 13+4i..16+4i, least-significant byte first, and appears on `cmd_data[32i+31:32i]`. `cmd_nwords` equals (L-13)/4, which is at most 16. Words at or above `cmd_nwords` read as zero.
- R5: `cmd_time` equals the stored timestamp plus the `time_ofs` value sampled at the accepted start, as a full 64-bit sum with carry across all bits.
- R6: While `cmd_valid` is high and `cmd_ready` is low, every command field holds its value.
- R7: A length byte of zero produces no command and ends playback.
- R8: `err_flags[0]` (underflow) is set when `cmd_late` is high during a handshake. `err_flags[1]` (unreachable) is set when `cmd_badch` is high during a handshake. Both flags are sticky, and the following records are still emitted.
- R9: A 1 in bit b of `err_clr` clears `err_flags[b]` and leaves the other bit alone. A new error in the same cycle wins over the clear.
- R10: `err_time` and `err_chan` capture the shifted time and the channel of an erroring event only when both flags were clear before it. Later errors leave them unchanged.
- R11: Stream bytes are read from consecutive addresses starting at the base. Each `mem_rd` is answered by one `mem_rvalid`, and no new request is issued before that answer arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | AW | Stream start address |
| time_ofs | input | 64 | Time shift added to each timestamp |
| start | input | 1 | Playback request pulse |
| busy | output | 1 | High while playback runs (enable readback) |
| err_clr | input | 2 | Write-one-to-clear mask for the error flags |
| err_flags | output | 2 | bit 0 underflow, bit 1 destination unreachable |
| err_time | output | 64 | Shifted time of the first failing event |
| err_chan | output | 24 | Channel of the first failing event |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | AW | Byte read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Sink accepts command |
| cmd_chan | output | 24 | Event channel |
| cmd_addr | output | 8 | Event address byte |
| cmd_time | output | 64 | Shifted event time |
| cmd_nwords | output | 5 | Number of valid data words |
| cmd_data | output | MAXW*32 | Data words, word 0 lowest |
| cmd_late | input | 1 | Sink: event time already past (sampled at handshake) |
| cmd_badch | input | 1 | Sink: channel invalid (sampled at handshake) |

## Verification
If the byte index loses its place, the very next command shows it, one record after the fault at most. The channel, time or word fields come out shifted by whole bytes, or a record gets cut short and the rest of the stream is read as headers. A stale data register shows up as nonzero words beyond `cmd_nwords` in the first short record that follows a long one. An error flag or capture register that updates at the wrong moment can be seen on `err_flags`/`err_time` as soon as the stream that should or should not have set it has finished. A busy state that does not clear shows up as a hang or as a missing return to idle after the terminator.

// File: rtl/evdma_pkg.sv
package evdma_pkg;
  localparam int HDR_BYTES = 13;
  localparam int IDX_W     = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_EMIT = 2'd3
  } play_st_t;
endpackage

// File: rtl/evdma_byte_rd.sv
module evdma_byte_rd #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          fetch,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr
);
  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  assign ptr_en = load | fetch;

  always_comb begin
    ptr_d = ptr_q;
    if (load)       ptr_d = base;
    else if (fetch) ptr_d = ptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign mem_rd   = fetch;
  assign mem_addr = ptr_q;
endmodule

// File: rtl/evdma_rec_asm.sv
module evdma_rec_asm
  import evdma_pkg::*;
#(
  parameter int MAXW = 16,
  parameter int CW   = 24,
  localparam int NW  = $clog2(MAXW + 1),
  localparam int WIX = $clog2(MAXW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic                 rvalid,
  input  logic [7:0]           rdata,
  input  logic                 cmd_ready,
  output logic                 busy,
  output logic                 fetch,
  output logic                 cmd_valid,
  output logic [CW-1:0]        chan,
  output logic [7:0]           addr,
  output logic [63:0]          stamp,
  output logic [NW-1:0]        nwords,
  output logic [MAXW-1:0][31:0] words
);
  play_st_t              st_q, st_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [7:0]            len_q, len_d;
  logic [CW-1:0]         chan_q, chan_d;
  logic [7:0]            addr_q, addr_d;
  logic [63:0]           ts_q, ts_d;
  logic [MAXW-1:0][31:0] data_q, data_d;
  logic [IDX_W-1:0]      k;
  logic [1:0]            csel;
  logic [2:0]            tsel;
  logic [7:0]            body;

  assign k    = idx_q - IDX_W'(HDR_BYTES);
  assign csel = idx_q[1:0] - 2'd1;
  assign tsel = idx_q[2:0] - 3'd4;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    len_d  = len_q;
    chan_d = chan_q;
    addr_d = addr_q;
    ts_d   = ts_q;
    data_d = data_q;
    unique case (st_q)
      ST_IDLE: if (go) begin
        st_d  = ST_REQ;
        idx_d = '0;
      end
      ST_REQ: st_d = ST_WAIT;
      ST_WAIT: if (rvalid) begin
        if (idx_q == '0) begin
          if (rdata == 8'd0) begin
            st_d = ST_IDLE;
          end else begin
            len_d  = rdata;
            data_d = '0;
            idx_d  = IDX_W'(1);
            st_d   = ST_REQ;
          end
        end else begin
          if (idx_q < IDX_W'(4))
            chan_d[csel*8 +: 8] = rdata;
          else if (idx_q < IDX_W'(12))
            ts_d[tsel*8 +: 8] = rdata;
          else if (idx_q == IDX_W'(12))
            addr_d = rdata;
          else if (int'(k[IDX_W-1:2]) < MAXW)
            data_d[k[WIX+1:2]][k[1:0]*8 +: 8] = rdata;
          if (idx_q == IDX_W'(len_q - 8'd1)) begin
            st_d  = ST_EMIT;
            idx_d = '0;
          end else begin
            idx_d = idx_q + IDX_W'(1);
            st_d  = ST_REQ;
          end
        end
      end
      ST_EMIT: if (cmd_ready) st_d = ST_REQ;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      len_q  <= '0;
      chan_q <= '0;
      addr_q <= '0;
      ts_q   <= '0;
      data_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      if (st_q == ST_WAIT && rvalid) begin
        len_q  <= len_d;
        chan_q <= chan_d;
        addr_q <= addr_d;
        ts_q   <= ts_d;
        data_q <= data_d;
      end
    end
  end

  assign body      = len_q - 8'd13;
  assign nwords    = body[NW+1:2];
  assign busy      = (st_q != ST_IDLE);
  assign fetch     = (st_q == ST_REQ);
  assign cmd_valid = (st_q == ST_EMIT);
  assign chan      = chan_q;
  assign addr      = addr_q;
  assign stamp     = ts_q;
  assign words     = data_q;
endmodule

// File: rtl/evdma_err_log.sv
module evdma_err_log #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs,
  input  logic          late,
  input  logic          badch,
  input  logic [63:0]   evt_time,
  input  logic [CW-1:0] evt_chan,
  input  logic [1:0]    clr,
  output logic [1:0]    flags,
  output logic [63:0]   cap_time,
  output logic [CW-1:0] cap_chan
);
  logic [1:0]    flags_q, flags_d, hit;
  logic [63:0]   time_q;
  logic [CW-1:0] chan_q;
  logic          cap_en;

  assign hit     = {badch & hs, late & hs};
  assign flags_d = (flags_q & ~clr) | hit;
  assign cap_en  = (hit != 2'b00) && (flags_q == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      chan_q <= '0;
    end else if (cap_en) begin
      time_q <= evt_time;
      chan_q <= evt_chan;
    end
  end

  assign flags    = flags_q;
  assign cap_time = time_q;
  assign cap_chan = chan_q;
endmodule

// File: rtl/evdma_player.sv
module evdma_player #(
  parameter int AW         = 32,
  parameter int MAXW       = 16,
  parameter int CW         = 24,
  parameter int ALIGN_LOG2 = 7,
  localparam int NW        = $clog2(MAXW + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      base_addr,
  input  logic [63:0]        time_ofs,
  input  logic               start,
  output logic               busy,
  input  logic [1:0]         err_clr,
  output logic [1:0]         err_flags,
  output logic [63:0]        err_time,
  output logic [CW-1:0]      err_chan,
  output logic               mem_rd,
  output logic [AW-1:0]      mem_addr,
  input  logic               mem_rvalid,
  input  logic [7:0]         mem_rdata,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [CW-1:0]      cmd_chan,
  output logic [7:0]         cmd_addr,
  output logic [63:0]        cmd_time,
  output logic [NW-1:0]      cmd_nwords,
  output logic [MAXW*32-1:0] cmd_data,
  input  logic               cmd_late,
  input  logic               cmd_badch
);
  logic                  go, fetch;
  logic [63:0]           ofs_q, stamp;
  logic [MAXW-1:0][31:0] words;

  assign go = start && !busy && (base_addr[ALIGN_LOG2-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ofs_q <= '0;
    else if (go) ofs_q <= time_ofs;
  end

  evdma_byte_rd #(.AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .load(go), .base(base_addr),
    .fetch(fetch), .mem_rd(mem_rd), .mem_addr(mem_addr)
  );

  evdma_rec_asm #(.MAXW(MAXW), .CW(CW)) u_asm (
    .clk(clk), .rst_n(rst_n), .go(go), .rvalid(mem_rvalid),
    .rdata(mem_rdata), .cmd_ready(cmd_ready), .busy(busy),
    .fetch(fetch), .cmd_valid(cmd_valid), .chan(cmd_chan),
    .addr(cmd_addr), .stamp(stamp), .nwords(cmd_nwords), .words(words)
  );

  assign cmd_time = stamp + ofs_q;
  assign cmd_data = words;

  evdma_err_log #(.CW(CW)) u_err (
    .clk(clk), .rst_n(rst_n), .hs(cmd_valid && cmd_ready),
    .late(cmd_late), .badch(cmd_badch), .evt_time(cmd_time),
    .evt_chan(cmd_chan), .clr(err_clr), .flags(err_flags),
    .cap_time(err_time), .cap_chan(err_chan)
  );
endmodule

// File: rtl/evdma_player_chk.sv
module evdma_player_chk #(
  parameter int AW         = 32,
  parameter int MAXW       = 16,
  parameter int CW         = 24,
  parameter int ALIGN_LOG2 = 7,
  localparam int NW        = $clog2(MAXW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] base_addr,
  input logic          start,
  input logic          busy,
  input logic [1:0]    err_clr,
  input logic [1:0]    err_flags,
  input logic          mem_rd,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [CW-1:0] cmd_chan,
  input logic [63:0]   cmd_time,
  input logic [NW-1:0] cmd_nwords
);
  // R1: misaligned start from idle is ignored
  a_r1_misaligned_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && base_addr[ALIGN_LOG2-1:0] != '0) |=> !busy);

  // R2: quiet outputs when idle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !cmd_valid));

  // R6: command held while stalled
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_time) && $stable(cmd_chan)));

  // R4: word count bound
  a_r4_word_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (int'(cmd_nwords) <= MAXW));

  // R8: flags sticky without a clear
  a_r8_sticky_under: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags[0] && !err_clr[0]) |=> err_flags[0]);
  a_r8_sticky_unreach: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flags[1] && !err_clr[1]) |=> err_flags[1]);

  // R11: one outstanding read
  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
endmodule

bind evdma_player evdma_player_chk #(
  .AW(AW), .MAXW(MAXW), .CW(CW), .ALIGN_LOG2(ALIGN_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .start(start),
  .busy(busy), .err_clr(err_clr), .err_flags(err_flags), .mem_rd(mem_rd),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_chan(cmd_chan),
  .cmd_time(cmd_time), .cmd_nwords(cmd_nwords)
);

// File: tb/evdma_player_tb.sv
module evdma_player_tb;
  localparam int AW = 32;
  localparam int MAXW = 16;

  typedef struct packed {
    logic [23:0]        chan;
    logic [7:0]         addr;
    logic [63:0]        tm;
    logic [4:0]         nw;
    logic [15:0][31:0]  data;
    logic               late;
    logic               bad;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [63:0] time_ofs = '0;
  logic start = 1'b0;
  logic busy;
  logic [1:0] err_clr = '0;
  logic [1:0] err_flags;
  logic [63:0] err_time;
  logic [23:0] err_chan;
  logic mem_rd;
  logic [AW-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [7:0] mem_rdata = '0;
  logic cmd_valid;
  logic cmd_ready = 1'b0;
  logic [23:0] cmd_chan;
  logic [7:0] cmd_addr;
  logic [63:0] cmd_time;
  logic [4:0] cmd_nwords;
  logic [MAXW*32-1:0] cmd_data;
  logic cmd_late = 1'b0;
  logic cmd_badch = 1'b0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rdy_cnt = 0;
  bit seen = 1'b0;
  logic [7:0] mem [0:1023];
  exp_t q[$];
  int wp;
  logic [63:0] cur_ofs;

  always #4 clk = ~clk;

  evdma_player u_dut (.*);

  always @(posedge clk) begin
    mem_rvalid <= mem_rd;
    mem_rdata  <= mem[mem_addr[9:0]];
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put8(input logic [7:0] b);
    mem[wp] = b;
    wp++;
  endtask

  task automatic add_rec(input logic [23:0] ch, input logic [63:0] ts, input logic [7:0] ad,
                         input int nw, input bit late, input bit bad);
    exp_t e;
    e = '0;
    put8(8'(13 + 4 * nw));
    for (int i = 0; i < 3; i++) put8(ch[i*8 +: 8]);
    for (int i = 0; i < 8; i++) put8(ts[i*8 +: 8]);
    put8(ad);
    for (int w = 0; w < nw; w++) begin
      logic [31:0] v;
      v = ts[31:0] ^ (32'h01020304 * 32'(w + 1)) ^ {8'(w), 24'hC3A500};
      e.data[w] = v;
      for (int i = 0; i < 4; i++) put8(v[i*8 +: 8]);
    end
    e.chan = ch; e.addr = ad; e.tm = ts + cur_ofs; e.nw = 5'(nw);
    e.late = late; e.bad = bad;
    q.push_back(e);
  endtask

  // scoreboard monitor: compares the head item, injects sink flags, drives ready
  always @(negedge clk) begin
    rdy_cnt++;
    if (rst_n && cmd_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7 unexpected command", 64'(cmd_chan), 64'(0));
      end else begin
        if (!seen) begin
          chk(cmd_chan == q[0].chan && cmd_addr == q[0].addr, "R3 chan/addr",
              {32'(cmd_chan), 32'(cmd_addr)}, {32'(q[0].chan), 32'(q[0].addr)});
          chk(cmd_time == q[0].tm, "R5 time", cmd_time, q[0].tm);
          chk(cmd_nwords == q[0].nw, "R4 nwords", 64'(cmd_nwords), 64'(q[0].nw));
          for (int w = 0; w < MAXW; w++)
            if (cmd_data[w*32 +: 32] != q[0].data[w])
              chk(1'b0, "R4 data word", 64'(cmd_data[w*32 +: 32]), 64'(q[0].data[w]));
          seen = 1'b1;
        end
        cmd_late  = q[0].late;
        cmd_badch = q[0].bad;
      end
    end
    cmd_ready = (rdy_cnt % 3) != 0;
    if (rst_n && cmd_valid && cmd_ready && q.size() > 0) begin
      void'(q.pop_front());
      seen = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic pulse_start(input logic [AW-1:0] b, input logic [63:0] o);
    base_addr = b; time_ofs = o;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    // stream A at 0x000: long, empty, short records (R3 R4 R5)
    wp = 0; cur_ofs = 64'h0000_0001_8000_0000;
    add_rec(24'h123456, 64'h0000_0000_9000_0001, 8'h11, 16, 0, 0);
    add_rec(24'hABCDEF, 64'h0102_0304_0506_0708, 8'h22, 0, 0, 0);
    add_rec(24'h000001, 64'hFFFF_FFFF_FFFF_FFF0, 8'h33, 1, 0, 0);
    put8(8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !cmd_valid && !mem_rd, "R2 reset idle", 64'(busy), 64'(0));
    chk(err_flags == 2'b00, "R8 reset flags", 64'(err_flags), 64'(0));

    // R1: misaligned base ignored
    pulse_start(32'h0000_0284, 64'h0);
    chk(!busy, "R1 misaligned ignored", 64'(busy), 64'(0));
    @(negedge clk);
    chk(!busy && !mem_rd, "R1 no read after misaligned", 64'(mem_rd), 64'(0));

    pulse_start(32'h0000_0000, cur_ofs);
    chk(busy, "R2 busy after start", 64'(busy), 64'(1));
    repeat (5) @(negedge clk);
    // R1: start while busy ignored (stream must continue unchanged)
    pulse_start(32'h0000_0200, 64'hDEAD);
    wait_idle();
    chk(q.size() == 0, "R7 stream A all emitted", 64'(q.size()), 64'(0));
    repeat (4) @(negedge clk);
    chk(!busy && !cmd_valid, "R2 idle after terminator", 64'(busy), 64'(0));
    chk(err_flags == 2'b00, "R8 no errors in A", 64'(err_flags), 64'(0));

    // stream B at 0x100 with errors (R8 R10)
    wp = 32'h100; cur_ofs = 64'h10;
    add_rec(24'h000AAA, 64'h500, 8'h01, 2, 1, 0);
    add_rec(24'h000BBB, 64'h600, 8'h02, 0, 0, 1);
    add_rec(24'h000CCC, 64'h700, 8'h03, 3, 1, 1);
    put8(8'h00);
    pulse_start(32'h0000_0100, cur_ofs);
    wait_idle();
    chk(q.size() == 0, "R8 playback continued after errors", 64'(q.size()), 64'(0));
    chk(err_flags == 2'b11, "R8 both flags", 64'(err_flags), 64'(3));
    chk(err_time == 64'h510, "R10 first time captured", err_time, 64'h510);
    chk(err_chan == 24'h000AAA, "R10 first chan captured", 64'(err_chan), 64'hAAA);

    // R9: per-bit write-one-to-clear
    err_clr = 2'b01;
    @(negedge clk);
    err_clr = 2'b00;
    chk(err_flags == 2'b10, "R9 clear bit0 only", 64'(err_flags), 64'(2));
    chk(err_time == 64'h510, "R10 capture kept on clear", err_time, 64'h510);
    err_clr = 2'b10;
    @(negedge clk);
    err_clr = 2'b00;
    chk(err_flags == 2'b00, "R9 clear bit1", 64'(err_flags), 64'(0));

    // stream C at 0x200: new first error captured after clear
    wp = 32'h200; cur_ofs = 64'hFFFF_FFFF_0000_0000;
    add_rec(24'h00D00D, 64'h1_0000_0001, 8'h44, 4, 0, 1);
    put8(8'h00);
    pulse_start(32'h0000_0200, cur_ofs);
    wait_idle();
    chk(q.size() == 0, "R11 stream C emitted", 64'(q.size()), 64'(0));
    chk(err_flags == 2'b10, "R8 unreachable only", 64'(err_flags), 64'(2));
    chk(err_time == 64'h1, "R10 recapture time carry", err_time, 64'h1);
    chk(err_chan == 24'h00D00D, "R10 recapture chan", 64'(err_chan), 64'hD00D);

    // R7: empty stream
    wp = 32'h380; put8(8'h00);
    pulse_start(32'h0000_0380, 64'h0);
    wait_idle();
    repeat (3) @(negedge clk);
    chk(!busy && q.size() == 0, "R7 empty stream", 64'(busy), 64'(0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule